// File: doc/BRIEF.md
# Video Memory Constant-Fill DMA Engine

This block writes one constant word into a run of consecutive locations of one of three video memories: the pattern RAM, the colour RAM or the scroll RAM. Software arms it by writing a command word whose DMA-request bit is set while the transfer-mode field selects fill. The engine then waits. The fill value is not part of the command. It arrives with the next data-port write, and that same write starts the transfer.

Once started, the engine produces one memory write per clock. Each write carries the target, the address and the fill word. The address steps by the auto-increment value that was present when the fill started. The colour and scroll memories are addressed by a 64-entry word index. The busy output stays high while writes are being produced. A new command abandons a fill that is still running.

Top module: `vmem_fill_dma`

## Requirements
- R1: After reset, `busy`, `pending` and `mem_we` are low.
- R2: On a command write, the held request bit takes the value of `cmd_dma_req` only when `dma_en` is 1. When `dma_en` is 0, the request bit of the command is ignored and the previously held value is used. `pending` becomes the value of this held request bit in the cycle after the command.
- R3: A fill starts only on a data-port write that occurs while `pending` is high and the command was issued with `xfer_mode` equal to 2'b10. Any other data-port write produces no memory write and leaves `pending` unchanged. Starting a fill clears `pending`.
- R4: The first write appears in the cycle after the starting data-port write, with `mem_wdata` equal to the data word. The k-th write (k counted from 0) uses byte address `cmd_addr + k*auto_inc`, wrapping modulo 2^16. The `auto_inc` value used is the one sampled when the fill started.
- R5: For target code 0 (pattern RAM), `mem_addr` is the full byte address. For target codes 1 (colour RAM), 2 (scroll RAM) and 3, `mem_addr` is the word index (byte address / 2) modulo 64, with the upper bits zero.
- R6: A fill length N from 1 to 65535 produces exactly N writes. A length of 0 produces 65536 writes.
- R7: `busy` is high exactly in the cycles in which `mem_we` is high. It falls in the cycle after the last write.
- R8: A command write while `busy` is high abandons the remaining count, so no write follows in the next cycle. The new command arms a fill by the rules of R2.
- R9: When a command write and a data-port write occur in the same cycle, the command is taken and the data write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word written this cycle |
| cmd_target | input | 2 | Target memory code (0 pattern, 1 colour, 2 scroll) |
| cmd_addr | input | 16 | Start byte address from the command |
| cmd_dma_req | input | 1 | DMA-request bit of the command |
| dma_en | input | 1 | DMA enable register bit |
| xfer_mode | input | 2 | Transfer mode field, 2'b10 selects fill |
| auto_inc | input | 8 | Auto-increment register |
| fill_len | input | 16 | Transfer length, 0 means 65536 |
| data_wr | input | 1 | Data-port write this cycle |
| data_val | input | 16 | Data-port word |
| pending | output | 1 | Fill armed, waiting for a data write |
| busy | output | 1 | Fill in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_target | output | 2 | Memory targeted by this write |
| mem_addr | output | 16 | Byte address or small-memory word index |
| mem_wdata | output | 16 | Fill word |

## Verification
The checker assumes that reset is applied before the first edge on which any property is evaluated. It also assumes that the target, address, mode and length inputs are meaningful only in the cycle of a command or data write. Beyond that, the properties require nothing of the inputs: commands, data writes and their collisions are all legal at any time. The bench changes the inputs only at falling edges. It draws random targets, start addresses, increments, lengths and fill words, and it mixes in directed collisions, aborts and the zero-length case.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

    typedef enum logic [1:0] {
        TGT_PATTERN = 2'd0,
        TGT_COLOUR  = 2'd1,
        TGT_SCROLL  = 2'd2,
        TGT_SPARE   = 2'd3
    } vfd_target_e;

    localparam logic [1:0] MODE_FILL = 2'b10;

endpackage

// File: rtl/vfd_arm.sv
module vfd_arm
    import vfd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_target,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_dma_req,
    input  logic              dma_en,
    input  logic [1:0]        xfer_mode,
    input  logic              start_take,
    output logic              armed_fill,
    output logic              pending_o,
    output logic [ADDR_W-1:0] arm_addr,
    output vfd_target_e       arm_target
);

    typedef struct packed {
        logic              req;
        logic              pending;
        logic              fill;
        logic [ADDR_W-1:0] addr;
        vfd_target_e       target;
    } arm_state_t;

    arm_state_t st_d, st_q;
    logic       req_eff;

    always_comb begin
        st_d    = st_q;
        req_eff = dma_en ? cmd_dma_req : st_q.req;
        if (cmd_wr) begin
            st_d.req     = req_eff;
            st_d.pending = req_eff;
            st_d.fill    = (xfer_mode == MODE_FILL);
            st_d.addr    = cmd_addr;
            st_d.target  = vfd_target_e'(cmd_target);
        end else if (start_take) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{req: 1'b0, pending: 1'b0, fill: 1'b0,
                      addr: '0, target: TGT_PATTERN};
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_fill = st_q.pending && st_q.fill;
    assign pending_o  = st_q.pending;
    assign arm_addr   = st_q.addr;
    assign arm_target = st_q.target;

endmodule

// File: rtl/vfd_seq.sv
module vfd_seq
    import vfd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    parameter int INC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  vfd_target_e       start_target,
    input  logic [INC_W-1:0]  start_inc,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [DATA_W-1:0] start_data,
    output logic              active,
    output logic [ADDR_W-1:0] cur_addr,
    output vfd_target_e       cur_target,
    output logic [DATA_W-1:0] cur_data
);

    localparam int CNT_W = LEN_W + 1;
    localparam logic [CNT_W-1:0] FULL_RUN = CNT_W'(1) << LEN_W;
    localparam logic [CNT_W-1:0] LAST_ONE = CNT_W'(1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  left;
        logic [ADDR_W-1:0] addr;
        logic [INC_W-1:0]  inc;
        logic [DATA_W-1:0] data;
        vfd_target_e       target;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (abort) begin
            st_d.busy = 1'b0;
            st_d.left = '0;
        end else if (st_q.busy) begin
            st_d.addr = st_q.addr + ADDR_W'(st_q.inc);
            st_d.left = st_q.left - LAST_ONE;
            if (st_q.left == LAST_ONE) begin
                st_d.busy = 1'b0;
            end
        end else if (start) begin
            st_d.busy   = 1'b1;
            st_d.left   = (start_len == '0) ? FULL_RUN : CNT_W'(start_len);
            st_d.addr   = start_addr;
            st_d.inc    = start_inc;
            st_d.data   = start_data;
            st_d.target = start_target;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, left: '0, addr: '0, inc: '0,
                      data: '0, target: TGT_PATTERN};
        end else begin
            st_q <= st_d;
        end
    end

    assign active     = st_q.busy;
    assign cur_addr   = st_q.addr;
    assign cur_target = st_q.target;
    assign cur_data   = st_q.data;

endmodule

// File: rtl/vfd_addr_fmt.sv
module vfd_addr_fmt
    import vfd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 6
) (
    input  vfd_target_e       target,
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [ADDR_W-1:0] out_addr
);

    logic [IDX_W-1:0] word_idx;

    assign word_idx = byte_addr[IDX_W:1];

    generate
        if (IDX_W < ADDR_W) begin : g_pad
            always_comb begin
                if (target == TGT_PATTERN) begin
                    out_addr = byte_addr;
                end else begin
                    out_addr = {{(ADDR_W-IDX_W){1'b0}}, word_idx};
                end
            end
        end else begin : g_full
            always_comb begin
                if (target == TGT_PATTERN) begin
                    out_addr = byte_addr;
                end else begin
                    out_addr = ADDR_W'(word_idx);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/vmem_fill_dma.sv
module vmem_fill_dma
    import vfd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    parameter int INC_W  = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_target,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_dma_req,
    input  logic              dma_en,
    input  logic [1:0]        xfer_mode,
    input  logic [INC_W-1:0]  auto_inc,
    input  logic [LEN_W-1:0]  fill_len,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_val,
    output logic              pending,
    output logic              busy,
    output logic              mem_we,
    output logic [1:0]        mem_target,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    logic              armed_fill;
    logic              start_fill;
    logic [ADDR_W-1:0] arm_addr;
    vfd_target_e       arm_target;
    logic              seq_active;
    logic [ADDR_W-1:0] seq_addr;
    vfd_target_e       seq_target;
    logic [DATA_W-1:0] seq_data;

    // a command in the same cycle outranks the data write
    assign start_fill = data_wr && !cmd_wr && armed_fill && !seq_active;

    vfd_arm #(.ADDR_W(ADDR_W)) u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_target  (cmd_target),
        .cmd_addr    (cmd_addr),
        .cmd_dma_req (cmd_dma_req),
        .dma_en      (dma_en),
        .xfer_mode   (xfer_mode),
        .start_take  (start_fill),
        .armed_fill  (armed_fill),
        .pending_o   (pending),
        .arm_addr    (arm_addr),
        .arm_target  (arm_target)
    );

    vfd_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .INC_W  (INC_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .abort        (cmd_wr),
        .start        (start_fill),
        .start_addr   (arm_addr),
        .start_target (arm_target),
        .start_inc    (auto_inc),
        .start_len    (fill_len),
        .start_data   (data_val),
        .active       (seq_active),
        .cur_addr     (seq_addr),
        .cur_target   (seq_target),
        .cur_data     (seq_data)
    );

    vfd_addr_fmt #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fmt (
        .target    (seq_target),
        .byte_addr (seq_addr),
        .out_addr  (mem_addr)
    );

    assign busy       = seq_active;
    assign mem_we     = seq_active;
    assign mem_target = seq_target;
    assign mem_wdata  = seq_data;

endmodule

// File: rtl/vfd_checker.sv
module vfd_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    parameter int INC_W  = 8,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic              data_wr,
    input logic              pending,
    input logic              busy,
    input logic              mem_we,
    input logic [1:0]        mem_target,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);

    // R3: a fill begins only after an uncontested data write while armed
    p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(data_wr) && $past(pending) && !$past(cmd_wr)));

    // R4: the address step stays the same for the whole run
    p_even_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(busy, 2) && !$past(cmd_wr) && !$past(cmd_wr, 2)
         && mem_target == 2'd0)
        |-> (ADDR_W'(mem_addr - $past(mem_addr)) ==
             ADDR_W'($past(mem_addr) - $past(mem_addr, 2))));

    // R4: word and target are held while the run continues
    p_word_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(cmd_wr)) |-> ($stable(mem_wdata) && $stable(mem_target)));

    // R5: small memories never see an index past 63
    p_small_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_target != 2'd0) |-> (mem_addr < ADDR_W'(1 << IDX_W)));

    // R8: a command during a run stops it on the next cycle
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> !busy);

    // R7: armed and running never overlap
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && pending));

endmodule

bind vmem_fill_dma vfd_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .INC_W  (INC_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .data_wr    (data_wr),
    .pending    (pending),
    .busy       (busy),
    .mem_we     (mem_we),
    .mem_target (mem_target),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
);

// File: tb/vmem_fill_dma_bench.sv
module vmem_fill_dma_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [1:0]  cmd_target = 2'd0;
    logic [15:0] cmd_addr = 16'd0;
    logic        cmd_dma_req = 1'b0;
    logic        dma_en = 1'b1;
    logic [1:0]  xfer_mode = 2'b10;
    logic [7:0]  auto_inc = 8'd2;
    logic [15:0] fill_len = 16'd1;
    logic        data_wr = 1'b0;
    logic [15:0] data_val = 16'd0;
    logic        pending, busy, mem_we;
    logic [1:0]  mem_target;
    logic [15:0] mem_addr, mem_wdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vmem_fill_dma u_vmem_fill_dma (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_target(cmd_target),
        .cmd_addr(cmd_addr), .cmd_dma_req(cmd_dma_req), .dma_en(dma_en),
        .xfer_mode(xfer_mode), .auto_inc(auto_inc), .fill_len(fill_len),
        .data_wr(data_wr), .data_val(data_val), .pending(pending), .busy(busy),
        .mem_we(mem_we), .mem_target(mem_target), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    function automatic logic [15:0] exp_addr(input logic [1:0] tgt, input logic [15:0] base,
                                             input logic [7:0] inc, input int k);
        logic [15:0] a;
        a = base + 16'(k * int'(inc));
        if (tgt == 2'd0) return a;
        return {10'd0, a[6:1]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            finish_run();
        end
    end

    task automatic command(input logic [1:0] tgt, input logic [15:0] addr,
                           input logic req, input logic en, input logic [1:0] mode);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_target = tgt; cmd_addr = addr;
        cmd_dma_req = req; dma_en = en; xfer_mode = mode;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    // pulse a data write; returns at the negedge after it
    task automatic data_write(input logic [15:0] v);
        @(negedge clk);
        data_wr = 1'b1; data_val = v;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    // full fill with per-write checks; first write is visible right after data_write
    task automatic run_fill(input logic [1:0] tgt, input logic [15:0] base,
                            input logic [7:0] inc, input logic [15:0] len,
                            input logic [15:0] v);
        int n, expn;
        bit ok_all;
        command(tgt, base, 1'b1, 1'b1, 2'b10);
        auto_inc = inc; fill_len = len;
        data_write(v);
        auto_inc = inc + 8'd5;  // later changes must not matter
        expn = (len == 16'd0) ? 65536 : int'(len);
        n = 0;
        ok_all = 1'b1;
        while (mem_we && n < 70000) begin
            if (mem_addr != exp_addr(tgt, base, inc, n) || mem_wdata != v || mem_target != tgt) begin
                if (ok_all)
                    check(1'b0, (tgt == 2'd0) ? "R4" : "R5", "write address",
                          mem_addr, exp_addr(tgt, base, inc, n));
                ok_all = 1'b0;
            end
            if (busy != 1'b1) ok_all = 1'b0;
            n++;
            @(negedge clk);
        end
        check(ok_all, "R4", "all writes match", ok_all, 1);
        check(n == expn, "R6", "write count", n, expn);
        check(!busy && !mem_we, "R7", "busy low after last", busy, 0);
        check(!pending, "R3", "pending cleared by start", pending, 0);
    endtask

    initial begin
        int seed;
        seed = 32'h1D5A;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !pending && !mem_we, "R1", "reset outputs", {busy, pending, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !pending && !mem_we, "R1", "after reset release", {busy, pending, mem_we}, 0);

        // R2: enable on, request bit taken
        command(2'd0, 16'h0100, 1'b1, 1'b1, 2'b10);
        check(pending, "R2", "pending after request", pending, 1);
        // R2: enable off, request 0 ignored, held 1 reused
        command(2'd0, 16'h0100, 1'b0, 1'b0, 2'b10);
        check(pending, "R2", "request ignored keeps pending", pending, 1);
        // clear held bit then request 1 with enable off
        command(2'd0, 16'h0100, 1'b0, 1'b1, 2'b10);
        check(!pending, "R2", "request cleared", pending, 0);
        command(2'd0, 16'h0100, 1'b1, 1'b0, 2'b10);
        check(!pending, "R2", "request ignored keeps clear", pending, 0);
        data_write(16'hBEEF);
        check(!mem_we, "R3", "no fill when not pending", mem_we, 0);

        // R3: pending but not fill mode
        command(2'd0, 16'h0040, 1'b1, 1'b1, 2'b00);
        data_write(16'h1234);
        check(!mem_we && !busy, "R3", "no fill in other mode", mem_we, 0);
        check(pending, "R3", "pending kept in other mode", pending, 1);

        // R9: collision of command and data write
        command(2'd1, 16'h0010, 1'b1, 1'b1, 2'b10);
        @(negedge clk);
        cmd_wr = 1'b1; data_wr = 1'b1; data_val = 16'h5555;
        @(negedge clk);
        cmd_wr = 1'b0; data_wr = 1'b0;
        check(!busy && pending, "R9", "command wins over data", busy, 0);
        @(negedge clk);
        check(!mem_we, "R9", "data write ignored", mem_we, 0);

        // directed fills
        run_fill(2'd0, 16'hFFFE, 8'd1, 16'd4, 16'hA5A5);
        run_fill(2'd1, 16'h007C, 8'd2, 16'd6, 16'h0EEE);   // index wrap 62,63,0..
        run_fill(2'd2, 16'h0000, 8'd0, 16'd3, 16'h07FF);
        run_fill(2'd0, 16'h1000, 8'd255, 16'd1, 16'h0001);

        // R8: abort mid-run
        command(2'd0, 16'h2000, 1'b1, 1'b1, 2'b10);
        auto_inc = 8'd2; fill_len = 16'd20;
        data_write(16'hCAFE);
        for (int i = 0; i < 4; i++) @(negedge clk);
        check(mem_we && mem_addr == 16'h2008, "R8", "fifth write before abort", mem_addr, 16'h2008);
        cmd_wr = 1'b1; cmd_dma_req = 1'b1; dma_en = 1'b1; xfer_mode = 2'b10;
        cmd_target = 2'd2; cmd_addr = 16'h0006;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(!mem_we && !busy, "R8", "no write after abort", mem_we, 0);
        check(pending, "R8", "new command armed", pending, 1);
        auto_inc = 8'd4; fill_len = 16'd2;
        data_write(16'h0042);
        check(mem_we && mem_addr == 16'd3 && mem_target == 2'd2, "R5", "scroll index", mem_addr, 3);

        // constrained random fills
        for (int it = 0; it < 20; it++) begin
            logic [1:0]  t;
            logic [15:0] b, l, v;
            logic [7:0]  s;
            t = 2'($urandom_range(0, 2));
            b = 16'($urandom);
            s = 8'($urandom_range(0, 40));
            l = 16'($urandom_range(1, 40));
            v = 16'($urandom);
            run_fill(t, b, s, l, v);
        end

        // R6: zero length means 65536
        run_fill(2'd0, 16'h0003, 8'd1, 16'd0, 16'h7E7E);

        finish_run();
    end

endmodule